// File: doc/BRIEF.md
# IO Segment Lookup and Page-Table-Entry Address Generator

This block turns a 32-bit device address into the physical address of the IO page-table entry that maps it. The top four address bits pick one of sixteen segment descriptors, and each descriptor covers 256 MB of device address space. The block holds these descriptors in a small register table that software loads through an indexed write port. The selected descriptor supplies a page-table base address and a page-size code. The code sets how far the in-segment address is shifted right to form a page number. That page number, scaled by the 8-byte entry size, is added to the base.

A global enable selects between translation and bypass. With the enable low, the device address comes back unchanged, zero-extended, and is flagged valid. With the enable high, a lookup that hits an invalid descriptor or an unsupported size code returns a fault instead of an address. Each lookup gives exactly one registered result one cycle after the request. Reading the page-table entry from memory and caching it are left to the logic downstream.

Top module: `iosl_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), res_done, res_valid and res_fault are 0, res_addr is 0, and every segment descriptor is invalid. A translated lookup issued after reset therefore faults.
- R2: The descriptor is selected by lk_addr[31:28]. A descriptor has these fields: bit 63 valid, bits [47:12] page-table base (the base is that field shifted left by 12), bits [11:5] pages-per-table count (stored only), bits [2:0] page-size code.
- R3: Size codes 1, 3, 5 and 7 select 4 KB, 64 KB, 1 MB and 16 MB pages. The page number is (lk_addr AND 0x0FFFFFFF) shifted right by 10 + 2×code. The table offset is the page number shifted left by 3 and masked with 0x7FFF8.
- R4: For a valid descriptor with a legal code and the enable high, res_addr = base + offset over the full 48-bit width, with carries propagating into the base bits. res_valid is 1 and res_fault is 0.
- R5: With the enable high, a lookup that selects a descriptor whose valid bit is 0 gives res_fault = 1 and res_valid = 0.
- R6: With the enable high, a valid descriptor whose size code is 0, 2, 4 or 6 gives res_fault = 1 and res_valid = 0.
- R7: With xlat_en low at the request, the result is res_valid = 1, res_fault = 0 and res_addr = lk_addr zero-extended. This holds whatever the selected descriptor contains.
- R8: res_done is 1 exactly in the cycle after a cycle with lk_req high. When res_done is 0, res_valid and res_fault are 0.
- R9: A descriptor written at a clock edge is used by a lookup requested in the following cycle. A lookup requested in the same cycle as a write to its own descriptor uses the previous contents.
- R10: Whenever res_fault is 1, res_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low selects bypass |
| seg_wr_en | input | 1 | Descriptor write strobe |
| seg_wr_idx | input | 4 | Descriptor index to write |
| seg_wr_data | input | 64 | Descriptor value to write |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Device address to look up |
| res_done | output | 1 | Result present this cycle |
| res_valid | output | 1 | Result address is usable |
| res_fault | output | 1 | Lookup faulted |
| res_addr | output | 48 | Page-table-entry address, or the bypassed address |

## Verification
Two functions can act in the same cycle: a descriptor write and a lookup that reads that same descriptor. The bench provokes this by raising seg_wr_en and lk_req in one cycle with seg_wr_idx equal to lk_addr[31:28]. The write changes validity, base and size code. The bench judges the result against its shadow copy of the old descriptor. It then checks that the next lookup returns the value computed from the new descriptor.

// File: rtl/iosl_pkg.sv
// Package iosl_pkg
// Shared descriptor field layout and page-size codes for the IO segment
// lookup block. The layout is fixed; address widths are module parameters.
package iosl_pkg;

    localparam int SD_VALID_BIT = 63;
    localparam int SD_BASE_LO   = 12;
    localparam int SD_CNT_LO    = 5;
    localparam int SD_CNT_HI    = 11;
    localparam int SD_CODE_LO   = 0;
    localparam int SD_CODE_HI   = 2;
    localparam int SD_CODE_W    = SD_CODE_HI - SD_CODE_LO + 1;

    // Smallest page shift (4 KB), used to size the page-number field
    localparam int MIN_PG_SHIFT = 12;
    // Bytes per page-table entry, as a shift
    localparam int PTE_SHIFT    = 3;

    typedef enum logic [SD_CODE_W-1:0] {
        PGSZ_4K  = 3'd1,
        PGSZ_64K = 3'd3,
        PGSZ_1M  = 3'd5,
        PGSZ_16M = 3'd7
    } pgsz_e;

endpackage

// File: rtl/iosl_seg_table.sv
// Module iosl_seg_table
// Register file of segment descriptors with one indexed write port and one
// combinational read port. A write lands at the clock edge, so a read in the
// same cycle returns the old value. Assumes rst_n is synchronous, active low.
module iosl_seg_table #(
    parameter int SEG_BITS = 4,
    parameter int ENT_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic [ENT_W-1:0]    wr_data,
    input  logic [SEG_BITS-1:0] rd_idx,
    output logic [ENT_W-1:0]    rd_data
);
    localparam int NUM_SEG = 1 << SEG_BITS;

    logic [ENT_W-1:0] ent_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        // Hold one descriptor; cleared (invalid) on reset, loaded on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (wr_en && (wr_idx == SEG_BITS'(g))) begin
                ent_q[g] <= wr_data;
            end
        end
    end

    // Select the descriptor addressed by the lookup
    always_comb begin
        rd_data = ent_q[rd_idx];
    end

endmodule

// File: rtl/iosl_pte_calc.sv
// Module iosl_pte_calc
// Purely combinational: decodes a descriptor's page-size code, forms the page
// number from the in-segment address bits and adds the scaled table offset to
// the page-table base. Flags an invalid descriptor or an illegal size code.
// Assumes PA_W - 12 base bits fit in the descriptor above bit 12.
module iosl_pte_calc
    import iosl_pkg::*;
#(
    parameter int IO_AW    = 32,
    parameter int SEG_BITS = 4,
    parameter int PA_W     = 48,
    parameter int ENT_W    = 64
) (
    input  logic [ENT_W-1:0] desc,
    input  logic [IO_AW-1:0] io_addr,
    output logic [PA_W-1:0]  pte_addr,
    output logic             seg_miss,
    output logic             bad_size
);
    localparam int OFF_W   = IO_AW - SEG_BITS;          // in-segment address bits
    localparam int IDX_W   = OFF_W - MIN_PG_SHIFT;      // widest page number
    localparam int TOFF_W  = IDX_W + PTE_SHIFT;         // table offset width
    localparam int BASE_W  = PA_W - SD_BASE_LO;
    localparam int SHAMT_W = $clog2(OFF_W + 1);

    logic [OFF_W-1:0]         seg_off;
    logic [SD_CODE_W-1:0]     code;
    logic [SHAMT_W-1:0]       shamt;
    logic                     code_ok;
    logic [OFF_W-1:0]         page_num;
    logic [TOFF_W-1:0]        tbl_off;
    logic [PA_W-1:0]          base;

    // Pull the fields used by the lookup out of the descriptor
    always_comb begin
        seg_off  = io_addr[OFF_W-1:0];
        code     = desc[SD_CODE_HI:SD_CODE_LO];
        base     = {desc[SD_BASE_LO+BASE_W-1:SD_BASE_LO], {SD_BASE_LO{1'b0}}};
        seg_miss = !desc[SD_VALID_BIT];
    end

    // Decode the size code into a page shift of 10 + 2*code
    always_comb begin
        code_ok = 1'b1;
        unique case (code)
            PGSZ_4K:  shamt = SHAMT_W'(10 + 2 * 1);
            PGSZ_64K: shamt = SHAMT_W'(10 + 2 * 3);
            PGSZ_1M:  shamt = SHAMT_W'(10 + 2 * 5);
            PGSZ_16M: shamt = SHAMT_W'(10 + 2 * 7);
            default: begin
                shamt   = SHAMT_W'(MIN_PG_SHIFT);
                code_ok = 1'b0;
            end
        endcase
        bad_size = !code_ok;
    end

    // Page number scaled to an 8-byte-granular offset inside the table
    always_comb begin
        page_num = seg_off >> shamt;
        tbl_off  = {page_num[IDX_W-1:0], {PTE_SHIFT{1'b0}}};
        pte_addr = base + PA_W'(tbl_off);
    end

endmodule

// File: rtl/iosl_resolve.sv
// Module iosl_resolve
// Combinational result selection: bypass when translation is off, fault
// (address forced to zero) on a miss or illegal size, otherwise the computed
// entry address. Assumes PA_W >= IO_AW.
module iosl_resolve #(
    parameter int IO_AW = 32,
    parameter int PA_W  = 48
) (
    input  logic             en,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [PA_W-1:0]  pte_addr,
    input  logic             seg_miss,
    input  logic             bad_size,
    output logic             ok,
    output logic             fault,
    output logic [PA_W-1:0]  addr
);
    // Choose between bypass, fault and translated address
    always_comb begin
        if (!en) begin
            ok    = 1'b1;
            fault = 1'b0;
            addr  = PA_W'(io_addr);
        end else if (seg_miss || bad_size) begin
            ok    = 1'b0;
            fault = 1'b1;
            addr  = '0;
        end else begin
            ok    = 1'b1;
            fault = 1'b0;
            addr  = pte_addr;
        end
    end

endmodule

// File: rtl/iosl_top.sv
// Module iosl_top
// IO segment lookup and page-table-entry address generator. A lookup request
// reads the descriptor chosen by the top address bits, computes the entry
// address and registers the outcome; the result appears one cycle later.
// Assumes a synchronous active-low reset and PA_W >= IO_AW.
module iosl_top #(
    parameter int IO_AW    = 32,
    parameter int SEG_BITS = 4,
    parameter int PA_W     = 48,
    parameter int ENT_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xlat_en,
    input  logic                seg_wr_en,
    input  logic [SEG_BITS-1:0] seg_wr_idx,
    input  logic [ENT_W-1:0]    seg_wr_data,
    input  logic                lk_req,
    input  logic [IO_AW-1:0]    lk_addr,
    output logic                res_done,
    output logic                res_valid,
    output logic                res_fault,
    output logic [PA_W-1:0]     res_addr
);
    logic [SEG_BITS-1:0] sel_idx;
    logic [ENT_W-1:0]    sel_desc;
    logic [PA_W-1:0]     calc_addr;
    logic                calc_miss;
    logic                calc_bad;
    logic                nxt_ok;
    logic                nxt_fault;
    logic [PA_W-1:0]     nxt_addr;

    // Segment index comes from the top address bits
    always_comb begin
        sel_idx = lk_addr[IO_AW-1 -: SEG_BITS];
    end

    iosl_seg_table #(
        .SEG_BITS (SEG_BITS),
        .ENT_W    (ENT_W)
    ) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_idx  (seg_wr_idx),
        .wr_data (seg_wr_data),
        .rd_idx  (sel_idx),
        .rd_data (sel_desc)
    );

    iosl_pte_calc #(
        .IO_AW    (IO_AW),
        .SEG_BITS (SEG_BITS),
        .PA_W     (PA_W),
        .ENT_W    (ENT_W)
    ) u_calc (
        .desc     (sel_desc),
        .io_addr  (lk_addr),
        .pte_addr (calc_addr),
        .seg_miss (calc_miss),
        .bad_size (calc_bad)
    );

    iosl_resolve #(
        .IO_AW (IO_AW),
        .PA_W  (PA_W)
    ) u_res (
        .en       (xlat_en),
        .io_addr  (lk_addr),
        .pte_addr (calc_addr),
        .seg_miss (calc_miss),
        .bad_size (calc_bad),
        .ok       (nxt_ok),
        .fault    (nxt_fault),
        .addr     (nxt_addr)
    );

    // Register the lookup outcome; outputs are quiet when no request was made
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_done  <= 1'b0;
            res_valid <= 1'b0;
            res_fault <= 1'b0;
            res_addr  <= '0;
        end else begin
            res_done  <= lk_req;
            res_valid <= lk_req && nxt_ok;
            res_fault <= lk_req && nxt_fault;
            res_addr  <= lk_req ? nxt_addr : '0;
        end
    end

endmodule

// File: rtl/iosl_chk.sv
// Module iosl_chk
// Protocol checks on the lookup result, attached to iosl_top by bind.
module iosl_chk #(
    parameter int IO_AW = 32,
    parameter int PA_W  = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xlat_en,
    input logic             lk_req,
    input logic [IO_AW-1:0] lk_addr,
    input logic             res_done,
    input logic             res_valid,
    input logic             res_fault,
    input logic [PA_W-1:0]  res_addr
);
    // R8: one result per request, one cycle later
    p_done_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_done);
    p_done_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_done);
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> (!res_valid && !res_fault));
    // R5/R6: a result is never both usable and faulted
    p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_fault));
    // R10: faulted results carry a zero address
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_addr == '0));
    // R7: bypass returns the request address unchanged
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !xlat_en) |=> (res_valid && !res_fault
                                  && res_addr == PA_W'($past(lk_addr))));
    // R3: translated entry addresses are 8-byte aligned
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && xlat_en) |=> (res_fault || res_addr[2:0] == 3'b000));
endmodule

bind iosl_top iosl_chk #(
    .IO_AW (IO_AW),
    .PA_W  (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlat_en   (xlat_en),
    .lk_req    (lk_req),
    .lk_addr   (lk_addr),
    .res_done  (res_done),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .res_addr  (res_addr)
);

// File: tb/iosl_top_tb.sv
`timescale 1ns/1ps
// Bench iosl_top_tb: sweeps every segment and size code with a shadow table
// and computes expected entry addresses arithmetically.
module iosl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [3:0]  seg_wr_idx = '0;
    logic [63:0] seg_wr_data = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_done, res_valid, res_fault;
    logic [47:0] res_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] shadow [16];

    always #2.5 clk = ~clk;

    iosl_top u_dut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
        .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .res_done(res_done), .res_valid(res_valid),
        .res_fault(res_fault), .res_addr(res_addr)
    );

    function automatic logic [63:0] mk_desc(input logic v, input logic [35:0] b,
                                            input logic [6:0] c, input logic [2:0] code);
        return {v, 15'b0, b, c, 2'b0, code};
    endfunction

    // Expected {done, valid, fault, addr} from the requirements
    function automatic logic [50:0] expect_res(input logic [63:0] d,
                                               input logic [31:0] a, input logic en);
        logic [47:0] base;
        logic [47:0] off;
        int sh;
        if (!en) return {1'b1, 1'b1, 1'b0, 16'b0, a};
        if (!d[63] || d[2:0] % 2 == 0) return {1'b1, 1'b0, 1'b1, 48'b0};
        sh   = 10 + 2 * int'(d[2:0]);
        base = {d[47:12], 12'b0};
        off  = (48'((a & 32'h0FFF_FFFF) >> sh) << 3) & 48'h7FFF8;
        return {1'b1, 1'b1, 1'b0, base + off};
    endfunction

    task automatic check(input string tag, input logic [50:0] exp);
        logic [50:0] got;
        got = {res_done, res_valid, res_fault, res_addr};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got done/valid/fault/addr=%b/%b/%b/%h expected %b/%b/%b/%h",
                     tag, got[50], got[49], got[48], got[47:0],
                     exp[50], exp[49], exp[48], exp[47:0]);
        end
    endtask

    task automatic write_desc(input logic [3:0] idx, input logic [63:0] d);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_idx = idx; seg_wr_data = d;
        @(negedge clk);
        seg_wr_en = 1'b0;
        shadow[idx] = d;
    endtask

    task automatic lookup(input logic [31:0] a, input logic en, input string tag);
        logic [50:0] exp;
        exp = expect_res(shadow[a[31:28]], a, en);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a; xlat_en = en;
        @(negedge clk);
        lk_req = 1'b0;
        check(tag, exp);
    endtask

    initial begin
        logic [31:0] offs [4];
        offs[0] = 32'h0000_0000; offs[1] = 32'h0FFF_FFFF;
        offs[2] = 32'h05A5_A5A8; offs[3] = 32'h0123_4567;
        for (int i = 0; i < 16; i++) shadow[i] = '0;

        repeat (3) @(negedge clk);
        check("R1 reset outputs", 51'b0);
        rst_n = 1'b1;
        // R1: all descriptors invalid after reset
        for (int s = 0; s < 16; s++) lookup({s[3:0], 28'h0001000}, 1'b1, "R1 invalid after reset");

        // R2 R3 R4 R6: sweep segments x size codes x addresses
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 8; c++) begin
                write_desc(s[3:0], mk_desc(1'b1, 36'h0_1234_0FF + 36'(s << 20),
                                           7'(c * 9), c[2:0]));
                for (int k = 0; k < 4; k++)
                    lookup({s[3:0], 28'h0} | offs[k], 1'b1,
                           (c % 2 == 1) ? "R3 R4 translated" : "R6 illegal size");
            end
        end

        // R2: distinct descriptors per segment, selected by top bits
        for (int s = 0; s < 16; s++)
            write_desc(s[3:0], mk_desc(1'b1, 36'(s * 36'h1_0000), 7'd1, 3'd5));
        for (int s = 0; s < 16; s++) lookup({s[3:0], 28'hABC_DEF0}, 1'b1, "R2 segment select");

        // R5: invalid descriptor with legal code
        write_desc(4'h6, mk_desc(1'b0, 36'hF_FFFF_FFFF, 7'd3, 3'd3));
        lookup(32'h6000_4000, 1'b1, "R5 invalid descriptor");
        lookup(32'h6FFF_FFFF, 1'b1, "R10 fault address zero");

        // R7: bypass ignores descriptor contents
        lookup(32'h6000_4000, 1'b0, "R7 bypass invalid seg");
        lookup(32'hF123_4567, 1'b0, "R7 bypass valid seg");
        lookup(32'h0000_0000, 1'b0, "R7 bypass zero");

        // R8: no result without a request
        @(negedge clk);
        check("R8 idle no result", 51'b0);

        // R9: same-cycle write/lookup sees old; next cycle sees new
        begin
            logic [63:0] nd;
            logic [50:0] exp_old, exp_new;
            nd = mk_desc(1'b1, 36'h8_0000_001, 7'd0, 3'd1);
            exp_old = expect_res(shadow[6], 32'h6ABC_D000, 1'b1);
            exp_new = expect_res(nd, 32'h6ABC_D000, 1'b1);
            @(negedge clk);
            seg_wr_en = 1'b1; seg_wr_idx = 4'h6; seg_wr_data = nd;
            lk_req = 1'b1; lk_addr = 32'h6ABC_D000; xlat_en = 1'b1;
            @(negedge clk);
            seg_wr_en = 1'b0;
            shadow[6] = nd;
            check("R9 same cycle old entry", exp_old);
            @(negedge clk);
            lk_req = 1'b0;
            check("R9 next cycle new entry", exp_new);
            @(negedge clk);
            check("R8 done drops", 51'b0);
        end

        // R1: reset in mid-run clears the table again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        lookup(32'h6ABC_D000, 1'b1, "R1 table cleared by reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule